// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block gathers 40 external level inputs and turns them into 40 interrupt outputs, under control of a small memory-mapped register file. The lines are split into two banks: bank 0 carries lines 0 to 31 and bank 1 carries lines 32 to 39. A fixed per-bank constant marks some lines as direct. A direct line, when enabled, copies its registered input level to its output. Every other line is configurable: it can trigger on a rising change, on a falling change or on both. It can also be fired by software. Each such trigger latches a sticky pending bit and emits a one-cycle output pulse.

Software reaches the block through a plain 32-bit port with a write strobe, a byte address, write data and combinational read data. The port has no handshake. Each bank holds six registers, at offsets (from the bank base) +0x00 enable mask, +0x04 event mask, +0x08 rising select, +0x0C falling select, +0x10 software trigger and +0x14 pending. The bank base is 0x00 for bank 0 and 0x20 for bank 1. Bit n of a bank register belongs to line 32*bank + n. The direct-line constant is 0xFF820000 for bank 0 and 0x87 for bank 1, and a 1 bit marks a direct line. Each input passes through one register stage, and the block compares that stored level with the current input on every clock.

Top module: `xint_ctrl`

## Requirements
- R1: After reset the enable mask of each bank reads back as that bank's direct-line constant (0xFF820000, 0x00000087). Every other register reads 0, and all outputs are low.
- R2: Only word-aligned addresses below 0x40 whose register index (address bits 4:2) is 0 to 5 are decoded. Any other address reads 0, and a write to it changes no register.
- R3: Written values are trimmed on store. The enable and event masks keep only the bank's valid lines (32 bits, 8 bits). The rising, falling and software-trigger registers also drop the direct lines (masks 0x007DFFFF and 0x78).
- R4: An enabled direct line drives its output with the input level registered on the previous clock. It drives the output low while its enable bit is 0, and it never sets a pending bit.
- R5: An enabled configurable line with rising select set, whose input goes from 0 to 1, sets its pending bit and pulses its output high for exactly the clock after the change. A falling change with falling select clear does nothing.
- R6: An enabled configurable line with falling select set behaves the same way on a 1-to-0 change. A rising change with rising select clear does nothing.
- R7: A configurable line whose enable bit is 0 never sets pending and never pulses. Its stored level still tracks the input, so later enabling it with the level unchanged produces no event.
- R8: A software-trigger write stores the trimmed value. Only bits that go from 0 to 1, belong to enabled lines and are not already pending set pending and pulse the output for one clock. Bits that are already set, disabled or pending cause no pulse.
- R9: Writing 1 to a pending bit of a configurable line clears it and also clears that line's software-trigger bit. Writing 0 bits, or 1 bits on direct lines, has no effect.
- R10: When a pending-clear write and a new qualifying edge hit the same line in the same clock, the pending bit stays set and the output pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 10 | Byte address within the 0x400 window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| lines_in | input | 40 | External level inputs, line n on bit n |
| irq_o | output | 40 | Interrupt outputs, line n on bit n |

## Verification
The assertions check three things on every clock. A configurable output never pulses unless its line was enabled the clock before. A newly set pending bit always comes with a pulse in the same clock. A pending bit only falls after a pending write. The direct-line outputs are also checked against the previous input sample and the current enable mask. Trimming on store, the undecoded addresses, the software-trigger qualifications (already set, disabled, already pending) and the collision of a pending clear with an edge are shown only by the bench's scenarios. Those scenarios read back through the register port and watch the outputs.

// File: rtl/xint_pkg.sv
// Package: shared constants and register-index encoding for the
// external interrupt edge controller. Assumes two banks, with bank 0 full width.
package xint_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 10;
    localparam int LINES0 = 32;
    localparam int LINES1 = 8;
    localparam logic [LINES0-1:0] DIRECT0 = 32'hFF82_0000;
    localparam logic [LINES1-1:0] DIRECT1 = 8'h87;

    // Register index as decoded from address bits 4:2
    typedef enum logic [2:0] {
        REG_ENABLE = 3'd0,
        REG_EVENT  = 3'd1,
        REG_RISE   = 3'd2,
        REG_FALL   = 3'd3,
        REG_SWTRIG = 3'd4,
        REG_PEND   = 3'd5
    } xint_reg_e;
endpackage

// File: rtl/xint_edge_det.sv
// Module: one register stage per line holding the last sampled level, plus
// rising/falling change flags against the current input.
// Assumes inputs are already synchronous to clk.
module xint_edge_det #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl_i,
    output logic [LINES-1:0] lvl_q,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);
    // Record the input level every clock, whatever the mask state
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_i;
    end

    // Change detection against the recorded level
    always_comb begin
        rise_o = lvl_i & ~lvl_q;
        fall_o = ~lvl_i & lvl_q;
    end
endmodule

// File: rtl/xint_bank.sv
// Module: one register bank of up to 32 lines. Holds the enable, event, rising,
// falling, software-trigger and pending registers, and forms the outputs.
// Assumes wr_en is already qualified by bank and address decode.
module xint_bank #(
    parameter int               LINES  = 32,
    parameter logic [LINES-1:0] DIRECT = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [2:0]                reg_sel,
    input  logic [LINES-1:0]          wdata,
    output logic [xint_pkg::DATA_W-1:0] rdata,
    input  logic [LINES-1:0]          lines_in,
    output logic [LINES-1:0]          irq_o
);
    import xint_pkg::*;

    localparam logic [LINES-1:0] CFG = ~DIRECT;

    logic [LINES-1:0] lvl_q, rise, fall;
    logic [LINES-1:0] en_q, evt_q, rsel_q, fsel_q, swt_q, pnd_q, pulse_q;
    logic [LINES-1:0] edge_hit, sw_hit, clr, sw_new;
    logic             wr_swt, wr_pnd;

    xint_edge_det #(.LINES(LINES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lines_in),
        .lvl_q  (lvl_q),
        .rise_o (rise),
        .fall_o (fall)
    );

    // Trigger qualification: edges, software sets and pending clears
    always_comb begin
        wr_swt   = wr_en && (reg_sel == REG_SWTRIG);
        wr_pnd   = wr_en && (reg_sel == REG_PEND);
        edge_hit = en_q & CFG & ((rise & rsel_q) | (fall & fsel_q));
        sw_new   = wdata & CFG;
        sw_hit   = wr_swt ? (sw_new & ~swt_q & en_q & ~pnd_q) : '0;
        clr      = wr_pnd ? (pnd_q & wdata & CFG) : '0;
    end

    // Register file and pending/pulse state; a new hit beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= DIRECT;
            evt_q   <= '0;
            rsel_q  <= '0;
            fsel_q  <= '0;
            swt_q   <= '0;
            pnd_q   <= '0;
            pulse_q <= '0;
        end else begin
            if (wr_en && reg_sel == REG_ENABLE) en_q   <= wdata;
            if (wr_en && reg_sel == REG_EVENT)  evt_q  <= wdata;
            if (wr_en && reg_sel == REG_RISE)   rsel_q <= wdata & CFG;
            if (wr_en && reg_sel == REG_FALL)   fsel_q <= wdata & CFG;
            swt_q   <= wr_swt ? sw_new : (swt_q & ~clr);
            pnd_q   <= (pnd_q & ~clr) | edge_hit | sw_hit;
            pulse_q <= edge_hit | sw_hit;
        end
    end

    // Outputs: direct lines follow level, configurable lines pulse
    always_comb begin
        irq_o = (en_q & DIRECT & lvl_q) | pulse_q;
    end

    // Read mux, zero-extended to the port width
    always_comb begin
        case (reg_sel)
            REG_ENABLE: rdata = DATA_W'(en_q);
            REG_EVENT:  rdata = DATA_W'(evt_q);
            REG_RISE:   rdata = DATA_W'(rsel_q);
            REG_FALL:   rdata = DATA_W'(fsel_q);
            REG_SWTRIG: rdata = DATA_W'(swt_q);
            REG_PEND:   rdata = DATA_W'(pnd_q);
            default:    rdata = '0;
        endcase
    end

    // R7: a configurable pulse needs the line enabled on the previous clock
    a_r7_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_o & CFG & ~$past(en_q)) == '0));

    // R5: a pending bit that newly rises comes with an output pulse
    a_r5_pend_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pnd_q & ~$past(pnd_q) & ~irq_o) == '0));

    // R9: pending only falls after a pending-register write
    a_r9_pend_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((~pnd_q & $past(pnd_q)) == '0) || $past(wr_pnd)));

    // R4: direct outputs equal the prior input sample gated by the enable
    a_r4_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_o & DIRECT) == ($past(lines_in) & en_q & DIRECT)));
endmodule

// File: rtl/xint_ctrl.sv
// Module: top of the external interrupt edge controller. Decodes the 32-bit
// register port onto two banks and concatenates their lines.
// Assumes aligned word accesses; everything else is treated as undecoded.
module xint_ctrl #(
    parameter int               LINES0  = xint_pkg::LINES0,
    parameter int               LINES1  = xint_pkg::LINES1,
    parameter logic [LINES0-1:0] DIRECT0 = xint_pkg::DIRECT0,
    parameter logic [LINES1-1:0] DIRECT1 = xint_pkg::DIRECT1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [xint_pkg::ADDR_W-1:0] addr,
    input  logic [xint_pkg::DATA_W-1:0] wdata,
    output logic [xint_pkg::DATA_W-1:0] rdata,
    input  logic [LINES0+LINES1-1:0]    lines_in,
    output logic [LINES0+LINES1-1:0]    irq_o
);
    import xint_pkg::*;

    localparam int NBANK = 2;

    logic             hit;
    logic             bank_sel;
    logic [2:0]       reg_sel;
    logic [DATA_W-1:0] bank_rd [NBANK];

    // Address decode: aligned, inside 0x00..0x3F, register index 0..5
    always_comb begin
        reg_sel  = addr[4:2];
        bank_sel = addr[5];
        hit      = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:6] == '0) &&
                   (reg_sel <= 3'd5);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        if (b == 0) begin : g_lo
            xint_bank #(.LINES(LINES0), .DIRECT(DIRECT0)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en && hit && !bank_sel),
                .reg_sel  (reg_sel),
                .wdata    (wdata[LINES0-1:0]),
                .rdata    (bank_rd[b]),
                .lines_in (lines_in[LINES0-1:0]),
                .irq_o    (irq_o[LINES0-1:0])
            );
        end else begin : g_hi
            xint_bank #(.LINES(LINES1), .DIRECT(DIRECT1)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en && hit && bank_sel),
                .reg_sel  (reg_sel),
                .wdata    (wdata[LINES1-1:0]),
                .rdata    (bank_rd[b]),
                .lines_in (lines_in[LINES0+LINES1-1:LINES0]),
                .irq_o    (irq_o[LINES0+LINES1-1:LINES0])
            );
        end
    end

    // Read data: selected bank, zero for undecoded addresses
    always_comb begin
        rdata = hit ? bank_rd[bank_sel] : '0;
    end
endmodule

// File: tb/tb_xint_ctrl.sv
`timescale 1ns/1ps
module tb_xint_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [39:0] lines = '0;
    logic [39:0] irq;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    xint_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lines_in(lines), .irq_o(irq)
    );

    // {address, write data, expected read-back}
    localparam int NV = 13;
    localparam logic [73:0] VEC [NV] = '{
        {10'h000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {10'h020, 32'hFFFF_FFFF, 32'h0000_00FF},
        {10'h004, 32'h1234_5678, 32'h1234_5678},
        {10'h024, 32'hFFFF_FFFF, 32'h0000_00FF},
        {10'h008, 32'hFFFF_FFFF, 32'h007D_FFFF},
        {10'h028, 32'hFFFF_FFFF, 32'h0000_0078},
        {10'h00C, 32'hFFFF_FFFF, 32'h007D_FFFF},
        {10'h02C, 32'hFFFF_FFFF, 32'h0000_0078},
        {10'h018, 32'hFFFF_FFFF, 32'h0000_0000},
        {10'h03C, 32'hFFFF_FFFF, 32'h0000_0000},
        {10'h040, 32'hFFFF_FFFF, 32'h0000_0000},
        {10'h002, 32'h0000_0000, 32'h0000_0000},
        {10'h000, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        addr = a; #1;
        d = rdata;
    endtask

    task automatic drive(input logic [39:0] v);
        @(negedge clk);
        lines = v;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; lines = '0; wr_en = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run is a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        do_reset();
        // R1: reset state
        chk("R1 irq", {24'h0, irq}, 64'h0);
        rd(10'h000, r); chk("R1 en0", {32'h0, r}, 64'hFF82_0000);
        rd(10'h020, r); chk("R1 en1", {32'h0, r}, 64'h87);
        for (int i = 1; i < 6; i++) begin
            rd(10'(i * 4), r);        chk("R1 bank0 reg", {32'h0, r}, 64'h0);
            rd(10'(32 + i * 4), r);   chk("R1 bank1 reg", {32'h0, r}, 64'h0);
        end

        // R2/R3: table of write then read-back
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][73:64], VEC[i][63:32]);
            rd(VEC[i][73:64], r);
            chk("R3/R2 table", {32'h0, r}, {32'h0, VEC[i][31:0]});
        end
        // R2: misaligned write left enable mask intact (last entry rewrote it)
        wr(10'h001, 32'h0);
        rd(10'h000, r); chk("R2 misaligned ignored", {32'h0, r}, 64'hFFFF_FFFF);

        do_reset();
        // R4: direct lines 17 and 32
        drive(40'h00_0002_0000);
        chk("R4 dir17", {24'h0, irq}, 64'h2_0000);
        rd(10'h014, r); chk("R4 no pend", {32'h0, r}, 64'h0);
        drive(40'h01_0002_0000);
        chk("R4 dir32", {24'h0, irq}, 64'h1_0002_0000);
        wr(10'h000, 32'hFF80_0000);
        chk("R4 masked", {24'h0, irq}, 64'h1_0000_0000);
        wr(10'h000, 32'hFF82_0000);
        chk("R4 unmasked", {24'h0, irq}, 64'h1_0002_0000);
        drive(40'h0);
        chk("R4 low", {24'h0, irq}, 64'h0);

        // R5: rising on line 3
        wr(10'h000, 32'hFF82_001A);
        wr(10'h008, 32'h0000_0028);
        wr(10'h00C, 32'h0000_0002);
        drive(40'h8);
        chk("R5 pulse", {24'h0, irq}, 64'h8);
        rd(10'h014, r); chk("R5 pend", {32'h0, r}, 64'h8);
        idle();
        chk("R5 pulse ends", {24'h0, irq}, 64'h0);
        drive(40'h0);
        chk("R5 fall ignored", {24'h0, irq}, 64'h0);

        // R6: falling on line 1
        drive(40'h2);
        chk("R6 rise ignored", {24'h0, irq}, 64'h0);
        rd(10'h014, r); chk("R6 pend before", {32'h0, r}, 64'h8);
        drive(40'h0);
        chk("R6 pulse", {24'h0, irq}, 64'h2);
        rd(10'h014, r); chk("R6 pend", {32'h0, r}, 64'hA);

        // R9: write-one-to-clear
        wr(10'h014, 32'h0);
        rd(10'h014, r); chk("R9 zero write", {32'h0, r}, 64'hA);
        wr(10'h014, 32'h0002_0008);
        rd(10'h014, r); chk("R9 clear one", {32'h0, r}, 64'h2);
        wr(10'h014, 32'hFFFF_FFFF);

        // R7: masked line 5 tracks level, no event on enable
        drive(40'h20);
        chk("R7 masked pulse", {24'h0, irq}, 64'h0);
        rd(10'h014, r); chk("R7 masked pend", {32'h0, r}, 64'h0);
        wr(10'h000, 32'hFF82_003A);
        chk("R7 enable no event", {24'h0, irq}, 64'h0);
        drive(40'h0);
        drive(40'h20);
        chk("R7 later edge", {24'h0, irq}, 64'h20);
        wr(10'h014, 32'hFFFF_FFFF);

        // R8: software trigger
        wr(10'h010, 32'h10);
        chk("R8 sw pulse", {24'h0, irq}, 64'h10);
        rd(10'h014, r); chk("R8 sw pend", {32'h0, r}, 64'h10);
        wr(10'h010, 32'h10);
        chk("R8 already set", {24'h0, irq}, 64'h0);
        wr(10'h014, 32'h10);
        rd(10'h014, r); chk("R9 pend clr", {32'h0, r}, 64'h0);
        rd(10'h010, r); chk("R9 swt clr", {32'h0, r}, 64'h0);
        wr(10'h010, 32'h40);
        chk("R8 disabled", {24'h0, irq}, 64'h0);
        rd(10'h014, r); chk("R8 disabled pend", {32'h0, r}, 64'h0);
        rd(10'h010, r); chk("R8 stored", {32'h0, r}, 64'h40);
        drive(40'h28);
        rd(10'h014, r); chk("R8 edge pend", {32'h0, r}, 64'h8);
        wr(10'h010, 32'h08);
        chk("R8 already pending", {24'h0, irq}, 64'h0);
        rd(10'h010, r); chk("R8 swt value", {32'h0, r}, 64'h8);
        wr(10'h020, 32'h8F);
        wr(10'h030, 32'h08);
        chk("R8 bank1 pulse", {24'h0, irq}, 64'h08_0000_0000);
        rd(10'h034, r); chk("R8 bank1 pend", {32'h0, r}, 64'h8);

        // R10: clear and edge on line 3 in the same clock
        drive(40'h20);
        @(negedge clk);
        lines = 40'h28; wr_en = 1'b1; addr = 10'h014; wdata = 32'h8;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk("R10 pulse", {24'h0, irq}, 64'h8);
        rd(10'h014, r); chk("R10 pend kept", {32'h0, r}, 64'h8);
        wr(10'h014, 32'h8);
        rd(10'h014, r); chk("R9 clear alone", {32'h0, r}, 64'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule